// File: doc/BRIEF.md
# Interrupt Redirection Pin Service

This block sits between a set of interrupt input lines and a message-based interrupt bus. Each of the input pins (24 by default) owns a 64-bit redirection entry. The entry says which vector to raise, how to deliver it, to which destination, with which polarity, whether the pin is edge- or level-sensitive, and whether it is masked. A requester reports a change on one pin. The block updates that pin's pending bit and services that pin alone. Servicing means the entry is decoded and at most one delivery message goes out on the bus. A status then returns to the requester: delivered, lost (the bus reported the interrupt coalesced) or masked.

Entries are written through a plain write port. A sweep command services every pin in ascending order without returning a per-pin status, and signals its end with a single pulse. When an entry selects the external-controller delivery mode, the vector is not taken from the entry. It is fetched from the legacy controller through a request/valid handshake, and the block waits for it before sending.

Top module: `ioredir_svc`

## Requirements
- R1: After reset every entry reads as masked (bit 16 set, all other bits zero), every pending bit is clear, `req_ready` is 1 and `msg_valid`, `rsp_valid`, `vec_req` and `sweep_done` are 0.
- R2: Entry fields are decoded as vector bits 7:0, delivery mode bits 10:8, destination mode bit 11, polarity bit 13, trigger bit 15 (1 = level), mask bit 16 and destination bits 63:56. The sent message carries exactly these values.
- R3: Servicing a pending pin whose mask bit is 1 returns status 2 (masked) and sends no message.
- R4: Asserting an unmasked pin sends one message. The status is 1 (delivered) when the bus acknowledges with `msg_accepted`=1 and 0 (lost) when it acknowledges with `msg_accepted`=0. Status value 3 never occurs.
- R5: Servicing an edge-triggered entry clears its pending bit whatever the bus answers, so a later sweep sends nothing for that pin.
- R6: A level-triggered pin stays pending after service, so a sweep delivers it again. Deasserting a level pin clears its pending bit, sends no message and returns status 1.
- R7: Deasserting an edge-triggered pin changes nothing, sends no message and returns status 1.
- R8: A pin number of 24 or above is ignored: status 1, no message, and no pending bit changes.
- R9: With delivery mode 7 the block raises `vec_req` and holds it until `vec_valid`. The message vector is `vec_data`, not the entry's vector, and the message follows the fetch.
- R10: A sweep services pins 0 to 23 in ascending order and sends messages only for pending unmasked pins. It pulses `sweep_done` once at the end and never pulses `rsp_valid`.
- R11: `msg_valid` and the message fields stay stable until `msg_ack`. `req_ready` is 0 while a service or sweep is in progress.
- R12: A masked pin that is asserted keeps its pending bit, so after it is unmasked a sweep delivers it once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Entry write strobe |
| cfg_pin | input | PIN_W | Entry index to write |
| cfg_data | input | 64 | Entry value |
| req_valid | input | 1 | Pin-change request, taken when `req_ready` is 1 |
| req_pin | input | PIN_W | Pin number of the request |
| req_level | input | 1 | New input level (1 asserts) |
| req_ready | output | 1 | Block idle and able to accept a request or sweep |
| rsp_valid | output | 1 | One-cycle status pulse for a pin request |
| rsp_status | output | 2 | 0 lost, 1 delivered, 2 masked |
| sweep_start | input | 1 | Start a service sweep over all pins (request wins if both) |
| sweep_done | output | 1 | One-cycle pulse at the end of a sweep |
| msg_valid | output | 1 | Delivery message present |
| msg_dest | output | 8 | Message destination |
| msg_dest_mode | output | 1 | Message destination mode |
| msg_dlv_mode | output | 3 | Message delivery mode |
| msg_vector | output | 8 | Message vector |
| msg_polarity | output | 1 | Message polarity |
| msg_level | output | 1 | Message trigger (1 = level) |
| msg_ack | input | 1 | Bus accepts the message this cycle |
| msg_accepted | input | 1 | With `msg_ack`: 1 delivered, 0 lost |
| vec_req | output | 1 | Vector fetch request to the legacy controller |
| vec_valid | input | 1 | Fetched vector present |
| vec_data | input | 8 | Fetched vector |

## Verification
The hardest state to reach from the ports is several pins pending at once, because an asserting request services its pin right away and edge entries then lose their pending bit. The bench builds that state through masked entries: it asserts edge pins while they are masked, so the pending bit survives. It also asserts level pins, which stay pending. It then unmasks the entries and starts a sweep, with a slow bus acknowledge so that messages must hold. The order of the logged messages shows the ascending service order and that each pending edge pin is delivered once.

// File: rtl/ioredir_pkg.sv
package ioredir_pkg;

    localparam int ENTRY_W = 64;
    localparam int VEC_W   = 8;
    localparam int DEST_W  = 8;
    localparam int MODE_W  = 3;

    localparam int POS_VEC_LO  = 0;
    localparam int POS_MODE_LO = 8;
    localparam int POS_DMODE   = 11;
    localparam int POS_POL     = 13;
    localparam int POS_TRIG    = 15;
    localparam int POS_MASK    = 16;
    localparam int POS_DEST_LO = 56;

    localparam logic [MODE_W-1:0]  DM_EXTERNAL = 3'b111;
    localparam logic [ENTRY_W-1:0] ENTRY_RESET = ENTRY_W'(1) << POS_MASK;

    typedef enum logic [1:0] {
        ST_LOST      = 2'd0,
        ST_DELIVERED = 2'd1,
        ST_MASKED    = 2'd2
    } svc_status_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_CHECK,
        S_FETCH,
        S_SEND
    } svc_state_e;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              dest_mode;
        logic [MODE_W-1:0] dlv_mode;
        logic              polarity;
        logic              level_trig;
        logic              masked;
        logic [VEC_W-1:0]  vector;
    } redir_fields_t;

    function automatic redir_fields_t decode_entry(input logic [ENTRY_W-1:0] e);
        redir_fields_t f;
        f.vector     = e[POS_VEC_LO  +: VEC_W];
        f.dlv_mode   = e[POS_MODE_LO +: MODE_W];
        f.dest_mode  = e[POS_DMODE];
        f.polarity   = e[POS_POL];
        f.level_trig = e[POS_TRIG];
        f.masked     = e[POS_MASK];
        f.dest       = e[POS_DEST_LO +: DEST_W];
        return f;
    endfunction

endpackage

// File: rtl/ioredir_table.sv
module ioredir_table
    import ioredir_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int PIN_W    = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [PIN_W-1:0]    wr_pin,
    input  logic [ENTRY_W-1:0]  wr_data,
    input  logic [PIN_W-1:0]    req_pin,
    output logic                req_is_level,
    input  logic [PIN_W-1:0]    svc_pin,
    output redir_fields_t       svc_fields
);
    localparam logic [PIN_W-1:0] MAX_PIN = PIN_W'(NUM_PINS - 1);

    logic [ENTRY_W-1:0] entry_q [NUM_PINS];

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                entry_q[g] <= ENTRY_RESET;
            else if (wr_en && wr_pin == PIN_W'(g))
                entry_q[g] <= wr_data;
        end
    end

    redir_fields_t req_fields;

    always_comb begin
        req_fields = decode_entry((req_pin <= MAX_PIN) ? entry_q[req_pin] : ENTRY_RESET);
        svc_fields = decode_entry((svc_pin <= MAX_PIN) ? entry_q[svc_pin] : ENTRY_RESET);
        req_is_level = req_fields.level_trig;
    end

endmodule

// File: rtl/ioredir_pending.sv
module ioredir_pending #(
    parameter int NUM_PINS = 24,
    parameter int PIN_W    = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                upd_en,
    input  logic [PIN_W-1:0]    upd_pin,
    input  logic                upd_level,
    input  logic                upd_is_level,
    input  logic                clr_en,
    input  logic [PIN_W-1:0]    clr_pin,
    output logic [NUM_PINS-1:0] pending
);

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_bit
        logic hit_upd;
        logic hit_clr;
        assign hit_upd = upd_en && (upd_pin == PIN_W'(g));
        assign hit_clr = clr_en && (clr_pin == PIN_W'(g));

        always_ff @(posedge clk) begin
            if (rst)
                pending[g] <= 1'b0;
            else if (hit_upd && upd_level)
                pending[g] <= 1'b1;
            else if (hit_upd && upd_is_level)
                pending[g] <= 1'b0;
            else if (hit_clr)
                pending[g] <= 1'b0;
        end
    end

endmodule

// File: rtl/ioredir_seq.sv
module ioredir_seq
    import ioredir_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int PIN_W    = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [PIN_W-1:0]    req_pin,
    input  logic                req_level,
    input  logic                sweep_start,
    output logic                req_ready,
    output logic                accept,
    input  logic [NUM_PINS-1:0] pending,
    output logic [PIN_W-1:0]    cur_pin,
    input  redir_fields_t       fields,
    output logic                clr_en,
    output logic                vec_req,
    input  logic                vec_valid,
    input  logic [VEC_W-1:0]    vec_data,
    output logic                msg_valid,
    output redir_fields_t       msg,
    input  logic                msg_ack,
    input  logic                msg_accepted,
    output logic                rsp_valid,
    output logic [1:0]          rsp_status,
    output logic                sweep_done
);
    localparam logic [PIN_W-1:0] MAX_PIN = PIN_W'(NUM_PINS - 1);

    svc_state_e  state_q;
    logic        sweeping_q;
    logic        assert_q;

    logic        in_range;
    logic        pend_hit;
    logic        step_done;
    svc_status_e step_status;

    assign req_ready = (state_q == S_IDLE);
    assign accept    = req_ready && req_valid;
    assign vec_req   = (state_q == S_FETCH);
    assign msg_valid = (state_q == S_SEND);

    always_comb begin
        in_range    = (cur_pin <= MAX_PIN);
        pend_hit    = in_range ? pending[cur_pin] : 1'b0;
        step_done   = 1'b0;
        step_status = ST_DELIVERED;
        clr_en      = 1'b0;
        unique case (state_q)
            S_CHECK: begin
                if (!assert_q || !pend_hit) begin
                    step_done = 1'b1;
                end else if (fields.masked) begin
                    step_done   = 1'b1;
                    step_status = ST_MASKED;
                end else begin
                    clr_en = !fields.level_trig;
                end
            end
            S_SEND: begin
                if (msg_ack) begin
                    step_done   = 1'b1;
                    step_status = msg_accepted ? ST_DELIVERED : ST_LOST;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= S_IDLE;
            sweeping_q <= 1'b0;
            assert_q   <= 1'b0;
            cur_pin    <= '0;
            msg        <= '0;
            rsp_valid  <= 1'b0;
            rsp_status <= ST_DELIVERED;
            sweep_done <= 1'b0;
        end else begin
            rsp_valid  <= 1'b0;
            sweep_done <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        cur_pin    <= req_pin;
                        assert_q   <= req_level;
                        sweeping_q <= 1'b0;
                        state_q    <= S_CHECK;
                    end else if (sweep_start) begin
                        cur_pin    <= '0;
                        assert_q   <= 1'b1;
                        sweeping_q <= 1'b1;
                        state_q    <= S_CHECK;
                    end
                end
                S_CHECK: begin
                    if (!step_done) begin
                        msg     <= fields;
                        state_q <= (fields.dlv_mode == DM_EXTERNAL) ? S_FETCH : S_SEND;
                    end
                end
                S_FETCH: begin
                    if (vec_valid) begin
                        msg.vector <= vec_data;
                        state_q    <= S_SEND;
                    end
                end
                default: ;
            endcase

            if (step_done) begin
                if (sweeping_q) begin
                    if (cur_pin == MAX_PIN) begin
                        sweep_done <= 1'b1;
                        state_q    <= S_IDLE;
                    end else begin
                        cur_pin <= cur_pin + 1'b1;
                        state_q <= S_CHECK;
                    end
                end else begin
                    rsp_valid  <= 1'b1;
                    rsp_status <= step_status;
                    state_q    <= S_IDLE;
                end
            end
        end
    end

endmodule

// File: rtl/ioredir_svc.sv
module ioredir_svc
    import ioredir_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int PIN_W    = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [PIN_W-1:0]    cfg_pin,
    input  logic [ENTRY_W-1:0]  cfg_data,
    input  logic                req_valid,
    input  logic [PIN_W-1:0]    req_pin,
    input  logic                req_level,
    output logic                req_ready,
    output logic                rsp_valid,
    output logic [1:0]          rsp_status,
    input  logic                sweep_start,
    output logic                sweep_done,
    output logic                msg_valid,
    output logic [DEST_W-1:0]   msg_dest,
    output logic                msg_dest_mode,
    output logic [MODE_W-1:0]   msg_dlv_mode,
    output logic [VEC_W-1:0]    msg_vector,
    output logic                msg_polarity,
    output logic                msg_level,
    input  logic                msg_ack,
    input  logic                msg_accepted,
    output logic                vec_req,
    input  logic                vec_valid,
    input  logic [VEC_W-1:0]    vec_data
);
    logic                accept;
    logic                req_is_level;
    logic [PIN_W-1:0]    cur_pin;
    redir_fields_t       cur_fields;
    redir_fields_t       msg;
    logic                clr_en;
    logic [NUM_PINS-1:0] pending;

    ioredir_table #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_table (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (cfg_we),
        .wr_pin       (cfg_pin),
        .wr_data      (cfg_data),
        .req_pin      (req_pin),
        .req_is_level (req_is_level),
        .svc_pin      (cur_pin),
        .svc_fields   (cur_fields)
    );

    ioredir_pending #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_pending (
        .clk          (clk),
        .rst          (rst),
        .upd_en       (accept),
        .upd_pin      (req_pin),
        .upd_level    (req_level),
        .upd_is_level (req_is_level),
        .clr_en       (clr_en),
        .clr_pin      (cur_pin),
        .pending      (pending)
    );

    ioredir_seq #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_pin      (req_pin),
        .req_level    (req_level),
        .sweep_start  (sweep_start),
        .req_ready    (req_ready),
        .accept       (accept),
        .pending      (pending),
        .cur_pin      (cur_pin),
        .fields       (cur_fields),
        .clr_en       (clr_en),
        .vec_req      (vec_req),
        .vec_valid    (vec_valid),
        .vec_data     (vec_data),
        .msg_valid    (msg_valid),
        .msg          (msg),
        .msg_ack      (msg_ack),
        .msg_accepted (msg_accepted),
        .rsp_valid    (rsp_valid),
        .rsp_status   (rsp_status),
        .sweep_done   (sweep_done)
    );

    assign msg_dest      = msg.dest;
    assign msg_dest_mode = msg.dest_mode;
    assign msg_dlv_mode  = msg.dlv_mode;
    assign msg_vector    = msg.vector;
    assign msg_polarity  = msg.polarity;
    assign msg_level     = msg.level_trig;

endmodule

// File: rtl/ioredir_svc_chk.sv
module ioredir_svc_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_ready,
    input logic       rsp_valid,
    input logic [1:0] rsp_status,
    input logic       sweep_done,
    input logic       msg_valid,
    input logic       msg_ack,
    input logic [7:0] msg_vector,
    input logic [7:0] msg_dest,
    input logic [2:0] msg_dlv_mode,
    input logic       vec_req,
    input logic       vec_valid
);

    // R1: leaving reset finds the block idle and quiet
    p_reset_idle_r1: assert property (@(posedge clk)
        $fell(rst) |-> (req_ready && !msg_valid && !rsp_valid && !vec_req));

    // R4: status code 3 is never produced
    p_status_legal_r4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_status != 2'd3));

    // R9: vector fetch held until answered
    p_vec_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (vec_req && !vec_valid) |=> vec_req);

    // R9: answered fetch is followed by the message
    p_vec_then_msg_r9: assert property (@(posedge clk) disable iff (rst)
        (vec_req && vec_valid) |=> msg_valid);

    // R9: fetch and message never overlap
    p_fetch_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(vec_req && msg_valid));

    // R10: sweep end never carries a pin status
    p_sweep_norsp_r10: assert property (@(posedge clk) disable iff (rst)
        !(sweep_done && rsp_valid));

    // R11: message held stable until acknowledged
    p_msg_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ack) |=> (msg_valid && $stable(msg_vector)
                                     && $stable(msg_dest) && $stable(msg_dlv_mode)));

    // R11: no new request taken while busy
    p_busy_r11: assert property (@(posedge clk) disable iff (rst)
        (msg_valid || vec_req) |-> !req_ready);

endmodule

bind ioredir_svc ioredir_svc_chk u_chk (.*);

// File: tb/ioredir_svc_bench.sv
module ioredir_svc_bench;

    localparam int PIN_W = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_pin = '0;
    logic [63:0] cfg_data = '0;
    logic        req_valid = 1'b0;
    logic [4:0]  req_pin = '0;
    logic        req_level = 1'b0;
    logic        req_ready;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic        sweep_start = 1'b0;
    logic        sweep_done;
    logic        msg_valid;
    logic [7:0]  msg_dest;
    logic        msg_dest_mode;
    logic [2:0]  msg_dlv_mode;
    logic [7:0]  msg_vector;
    logic        msg_polarity;
    logic        msg_level;
    logic        msg_ack = 1'b0;
    logic        msg_accepted = 1'b0;
    logic        vec_req;
    logic        vec_valid = 1'b0;
    logic [7:0]  vec_data = '0;

    always #2 clk = ~clk;

    ioredir_svc #(.NUM_PINS(24), .PIN_W(PIN_W)) u_ioredir_svc (.*);

    int n_checks = 0;
    int n_fail   = 0;

    // bus model state
    logic       bus_accept = 1'b1;
    int         ack_delay  = 0;
    int         vec_delay  = 0;
    logic [7:0] ext_vector = 8'h00;
    int         msg_cnt    = 0;
    int         vec_cnt    = 0;
    logic [7:0] log_vec  [32];
    logic [7:0] log_dest [32];
    logic [2:0] log_mode [32];
    logic       log_dmode[32];
    logic       log_pol  [32];
    logic       log_lvl  [32];

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input logic [7:0] vec, input logic [2:0] dm,
                                       input logic dmode, input logic pol, input logic lvl,
                                       input logic msk, input logic [7:0] dest);
        return {dest, 39'b0, msk, lvl, 1'b0, pol, 1'b0, dmode, dm, vec};
    endfunction

    // message responder
    initial begin
        int waited = 0;
        forever begin
            @(negedge clk);
            if (msg_ack) begin
                msg_ack = 1'b0;
            end else if (msg_valid) begin
                if (waited < ack_delay) begin
                    waited++;
                end else begin
                    if (msg_cnt < 32) begin
                        log_vec[msg_cnt]   = msg_vector;
                        log_dest[msg_cnt]  = msg_dest;
                        log_mode[msg_cnt]  = msg_dlv_mode;
                        log_dmode[msg_cnt] = msg_dest_mode;
                        log_pol[msg_cnt]   = msg_polarity;
                        log_lvl[msg_cnt]   = msg_level;
                    end
                    msg_cnt++;
                    msg_ack      = 1'b1;
                    msg_accepted = bus_accept;
                    waited       = 0;
                end
            end
        end
    end

    // vector responder
    initial begin
        int waited = 0;
        forever begin
            @(negedge clk);
            if (vec_valid) begin
                vec_valid = 1'b0;
            end else if (vec_req) begin
                if (waited < vec_delay) begin
                    waited++;
                end else begin
                    vec_cnt++;
                    vec_valid = 1'b1;
                    vec_data  = ext_vector;
                    waited    = 0;
                end
            end
        end
    end

    task automatic write_entry(input logic [4:0] pin, input logic [63:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_pin = pin; cfg_data = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pin_event(input logic [4:0] pin, input logic lvl, output logic [1:0] st);
        @(negedge clk);
        req_valid = 1'b1; req_pin = pin; req_level = lvl;
        @(negedge clk);
        req_valid = 1'b0;
        st = 2'd3;
        for (int i = 0; i < 100; i++) begin
            if (rsp_valid) begin
                st = rsp_status;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic sweep(output int n_done, output int n_rsp, output logic busy_seen);
        @(negedge clk);
        sweep_start = 1'b1;
        @(negedge clk);
        sweep_start = 1'b0;
        busy_seen = !req_ready;
        n_done = 0; n_rsp = 0;
        for (int i = 0; i < 500; i++) begin
            if (rsp_valid) n_rsp++;
            if (sweep_done) begin
                n_done++;
                break;
            end
            @(negedge clk);
        end
        repeat (3) begin
            @(negedge clk);
            if (sweep_done) n_done++;
            if (rsp_valid) n_rsp++;
        end
    endtask

    task automatic t_reset;
        logic [1:0] st;
        int m0;
        check("R1 req_ready", req_ready, 1);
        check("R1 msg_valid", msg_valid, 0);
        check("R1 rsp_valid", rsp_valid, 0);
        check("R1 vec_req", vec_req, 0);
        check("R1 sweep_done", sweep_done, 0);
        m0 = msg_cnt;
        pin_event(5'd5, 1'b1, st);
        check("R1 default entry masked", st, 2);
        check("R3 no msg when masked", msg_cnt - m0, 0);
    endtask

    task automatic t_edge_fixed;
        logic [1:0] st;
        int m0;
        write_entry(5'd3, mk(8'h41, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 8'hA5));
        bus_accept = 1'b1;
        m0 = msg_cnt;
        pin_event(5'd3, 1'b1, st);
        check("R4 delivered status", st, 1);
        check("R4 one message", msg_cnt - m0, 1);
        check("R2 vector", log_vec[m0], 8'h41);
        check("R2 dest", log_dest[m0], 8'hA5);
        check("R2 dlv mode", log_mode[m0], 0);
        check("R2 dest mode", log_dmode[m0], 1);
        check("R2 polarity", log_pol[m0], 1);
        check("R2 trigger", log_lvl[m0], 0);
        bus_accept = 1'b0;
        m0 = msg_cnt;
        pin_event(5'd3, 1'b1, st);
        check("R4 lost status", st, 0);
        check("R4 lost still sent", msg_cnt - m0, 1);
        bus_accept = 1'b1;
    endtask

    task automatic t_edge_cleared;
        int nd, nr, m0;
        logic busy;
        m0 = msg_cnt;
        sweep(nd, nr, busy);
        check("R5 edge pin not resent", msg_cnt - m0, 0);
        check("R10 done pulse once", nd, 1);
    endtask

    task automatic t_level;
        logic [1:0] st;
        int nd, nr, m0;
        logic busy;
        write_entry(5'd7, mk(8'h52, 3'd1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h03));
        m0 = msg_cnt;
        pin_event(5'd7, 1'b1, st);
        check("R6 level delivered", st, 1);
        check("R6 level msg", msg_cnt - m0, 1);
        check("R2 level trigger bit", log_lvl[m0], 1);
        check("R2 mode 1", log_mode[m0], 1);
        m0 = msg_cnt;
        sweep(nd, nr, busy);
        check("R6 level stays pending", msg_cnt - m0, 1);
        check("R6 redelivered vector", log_vec[m0], 8'h52);
        m0 = msg_cnt;
        pin_event(5'd7, 1'b0, st);
        check("R6 deassert status", st, 1);
        check("R6 deassert no msg", msg_cnt - m0, 0);
        sweep(nd, nr, busy);
        check("R6 cleared after deassert", msg_cnt - m0, 0);
    endtask

    task automatic t_edge_low_and_range;
        logic [1:0] st;
        int nd, nr, m0;
        logic busy;
        m0 = msg_cnt;
        pin_event(5'd3, 1'b0, st);
        check("R7 edge deassert status", st, 1);
        check("R7 edge deassert no msg", msg_cnt - m0, 0);
        pin_event(5'd24, 1'b1, st);
        check("R8 pin 24 status", st, 1);
        pin_event(5'd31, 1'b1, st);
        check("R8 pin 31 status", st, 1);
        sweep(nd, nr, busy);
        check("R8 no message or pending change", msg_cnt - m0, 0);
    endtask

    task automatic t_extint;
        logic [1:0] st;
        int m0, v0;
        write_entry(5'd10, mk(8'h11, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 8'h22));
        vec_delay  = 3;
        ext_vector = 8'hC3;
        m0 = msg_cnt; v0 = vec_cnt;
        pin_event(5'd10, 1'b1, st);
        check("R9 status", st, 1);
        check("R9 one fetch", vec_cnt - v0, 1);
        check("R9 one message", msg_cnt - m0, 1);
        check("R9 fetched vector used", log_vec[m0], 8'hC3);
        check("R9 mode carried", log_mode[m0], 7);
        vec_delay = 0;
    endtask

    task automatic t_masked_keep;
        logic [1:0] st;
        int nd, nr, m0;
        logic busy;
        write_entry(5'd12, mk(8'h66, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h01));
        m0 = msg_cnt;
        pin_event(5'd12, 1'b1, st);
        check("R3 masked status", st, 2);
        check("R3 masked no msg", msg_cnt - m0, 0);
        write_entry(5'd12, mk(8'h66, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01));
        sweep(nd, nr, busy);
        check("R12 kept pending delivered", msg_cnt - m0, 1);
        check("R12 vector", log_vec[m0], 8'h66);
        m0 = msg_cnt;
        sweep(nd, nr, busy);
        check("R12 delivered only once", msg_cnt - m0, 0);
    endtask

    task automatic t_sweep_order;
        logic [1:0] st;
        int nd, nr, m0;
        logic busy;
        write_entry(5'd20, mk(8'h14, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h04));
        write_entry(5'd2,  mk(8'h02, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h04));
        write_entry(5'd9,  mk(8'h09, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h04));
        pin_event(5'd20, 1'b1, st);
        pin_event(5'd2, 1'b1, st);
        pin_event(5'd9, 1'b1, st);
        check("R12 masked edge status", st, 2);
        write_entry(5'd9, mk(8'h09, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h04));
        ack_delay = 2;
        m0 = msg_cnt;
        sweep(nd, nr, busy);
        check("R10 three messages", msg_cnt - m0, 3);
        check("R10 first pin 2", log_vec[m0], 8'h02);
        check("R10 second pin 9", log_vec[m0+1], 8'h09);
        check("R10 third pin 20", log_vec[m0+2], 8'h14);
        check("R10 single done", nd, 1);
        check("R10 no rsp during sweep", nr, 0);
        check("R11 busy during sweep", busy, 1);
        ack_delay = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_edge_fixed();
        t_edge_cleared();
        t_level();
        t_edge_low_and_range();
        t_extint();
        t_masked_keep();
        t_sweep_order();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule